// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block executes the six control and status register instructions of a 32-bit integer pipeline against a small on-block register file. On every accepted instruction it reads the addressed CSR, computes a replacement value (plain write, bit set or bit clear), stores that value, and returns the value read to the integer register file through a registered writeback port one cycle later. The operand is either the rs1 register value or the 5-bit rs1 field zero-extended, chosen by the top bit of funct3.

The set of implemented addresses is a parameter list. An address not in the list reads as zero and takes no writes. Instructions with funct3 000 (environment call and breakpoint) or the reserved funct3 100, words with any other major opcode, and cycles without the valid strobe leave every CSR and the writeback port untouched. A destination of x0 suppresses only the register writeback. The CSR update still happens.

Top module: `csr_rmw_unit`

## Requirements
- R1: After a synchronous active-low reset every implemented CSR holds zero and `wb_we` is low.
- R2: funct3 001 (register write) stores `rs1_value` into the addressed CSR.
- R3: funct3 010 (register set) stores old OR `rs1_value`.
- R4: funct3 011 (register clear) stores old AND NOT `rs1_value`.
- R5: funct3 101, 110 and 111 behave like 001, 010 and 011, but the operand is `rs1_idx` zero-extended to 32 bits and `rs1_value` has no effect.
- R6: For an accepted instruction with a nonzero rd, on the clock edge after issue `wb_we` goes high for one cycle, `wb_data` carries the CSR value from before the update and `wb_idx` carries rd.
- R7: With rd equal to 0, `wb_we` stays low but the CSR update still happens.
- R8: An address outside the implemented list reads as zero and a write to it changes no CSR.
- R9: funct3 000 and 100 change no CSR and leave `wb_we` low.
- R10: An instruction word whose opcode is not 1110011, or any cycle with `op_valid` low, changes no CSR and leaves `wb_we` low.
- R11: Instructions may issue on consecutive cycles. Each one reads the value left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 7 | Major opcode field of the instruction word |
| funct3 | input | 3 | Operation select field |
| csr_addr | input | 12 | CSR address field |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | rs1 field, which is also the immediate operand |
| rs1_value | input | 32 | Value read from register rs1 |
| wb_we | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Register writeback index |
| wb_data | output | 32 | Prior CSR value for writeback |

## Verification
The assertions assume that the address list holds distinct entries, so at most one entry matches. They also assume that inputs are stable across each rising edge. The bench drives every input on the falling edge and uses the default list of four distinct addresses, plus one address outside the list. It sweeps every funct3 code over each address with several register and immediate operands, including rd of zero. An independent model holds the expected CSR contents. After the sweeps, and after each no-effect case, the bench reads every CSR back with a set instruction whose operand is zero.

// File: rtl/csr_rmw_pkg.sv
// Package csr_rmw_pkg: shared types and constants of the CSR read-modify-write unit.
// Assumes a 12-bit CSR address space and the system major opcode 1110011.
package csr_rmw_pkg;
    localparam int CSR_ADDR_W = 12;
    localparam int ZIMM_W     = 5;
    localparam int REG_IDX_W  = 5;
    localparam logic [6:0] SYSTEM_OPCODE = 7'b1110011;

    // Kind of CSR update an accepted instruction performs
    typedef enum logic [1:0] {
        CSR_NONE  = 2'b00,
        CSR_WRITE = 2'b01,
        CSR_SET   = 2'b10,
        CSR_CLEAR = 2'b11
    } csr_kind_e;

    // Decoded control for one instruction
    typedef struct packed {
        csr_kind_e kind;
        logic      use_imm;
    } csr_ctl_t;
endpackage

// File: rtl/csr_op_decode.sv
// Module csr_op_decode: turns valid, opcode and funct3 into an update kind and
// an operand select. Assumes the bottom two funct3 bits pick write/set/clear and
// the top bit picks the zero-extended immediate. 000 and 100 decode to no operation.
module csr_op_decode
    import csr_rmw_pkg::*;
(
    input  logic       op_valid,
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    output csr_ctl_t   ctl
);
    // Classify the instruction as no-op or one of the three update kinds
    always_comb begin
        ctl.use_imm = funct3[2];
        if (op_valid && (opcode == SYSTEM_OPCODE)) begin
            ctl.kind = csr_kind_e'(funct3[1:0]);
        end else begin
            ctl.kind = CSR_NONE;
        end
    end

    // Guard: an active kind only ever comes from a valid system-opcode word
    always_comb begin
        // R10
        active_needs_sys_chk: assert (ctl.kind == CSR_NONE ||
                                      (op_valid && opcode == SYSTEM_OPCODE));
        // R9
        noop_codes_chk: assert (!(funct3[1:0] == 2'b00 && ctl.kind != CSR_NONE));
    end
endmodule

// File: rtl/csr_update_alu.sv
// Module csr_update_alu: selects the operand (register value or zero-extended
// immediate) and forms the replacement CSR value for write, set and clear.
// Assumes old_val is the current content of the addressed CSR.
module csr_update_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_kind_e         kind,
    input  logic              use_imm,
    input  logic [XLEN-1:0]   rs1_value,
    input  logic [ZIMM_W-1:0] zimm,
    input  logic [XLEN-1:0]   old_val,
    output logic [XLEN-1:0]   new_val,
    output logic              wr_en
);
    localparam int PAD_W = XLEN - ZIMM_W;

    logic [XLEN-1:0] operand;

    // Pick the operand source and zero-extend the immediate
    always_comb begin
        operand = use_imm ? {{PAD_W{1'b0}}, zimm} : rs1_value;
    end

    // Compute the replacement value for the selected update kind
    always_comb begin
        wr_en = (kind != CSR_NONE);
        unique case (kind)
            CSR_WRITE: new_val = operand;
            CSR_SET:   new_val = old_val | operand;
            CSR_CLEAR: new_val = old_val & ~operand;
            default:   new_val = old_val;
        endcase
    end

    // Guard: set never drops a bit, clear never raises one
    always_comb begin
        // R3
        set_keeps_bits_chk: assert (kind != CSR_SET || (new_val & old_val) == old_val);
        // R4
        clear_adds_none_chk: assert (kind != CSR_CLEAR || (new_val & ~old_val) == '0);
    end
endmodule

// File: rtl/csr_file.sv
// Module csr_file: a parameterised set of CSRs with a combinational read and a
// synchronous write. Assumes ADDR_LIST holds NUM_CSR distinct 12-bit addresses,
// entry i in bits [12*i +: 12]. Unlisted addresses read zero and take no writes.
module csr_file
    import csr_rmw_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_CSR = 4,
    parameter logic [NUM_CSR*CSR_ADDR_W-1:0] ADDR_LIST =
        {12'hC00, 12'h340, 12'h305, 12'h300}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CSR_ADDR_W-1:0] addr,
    input  logic                  wr_en,
    input  logic [XLEN-1:0]       wr_data,
    output logic [XLEN-1:0]       rd_data
);
    localparam int STORE_W = NUM_CSR * XLEN;

    logic [NUM_CSR-1:0] hit;
    logic [STORE_W-1:0] store;

    for (genvar i = 0; i < NUM_CSR; i++) begin : g_entry
        assign hit[i] = (addr == ADDR_LIST[i*CSR_ADDR_W +: CSR_ADDR_W]);

        // Hold one CSR: clear on reset, load on a write that hits this entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store[i*XLEN +: XLEN] <= '0;
            end else if (wr_en && hit[i]) begin
                store[i*XLEN +: XLEN] <= wr_data;
            end
        end
    end

    // Return the content of the matching entry, zero when nothing matches
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (hit[i]) begin
                rd_data = rd_data | store[i*XLEN +: XLEN];
            end
        end
    end

    // R8
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R8
    miss_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit == '0) |=> $stable(store));
    // R8
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (rd_data == '0));
    // R10
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store));
endmodule

// File: rtl/csr_rmw_unit.sv
// Module csr_rmw_unit: top of the CSR read-modify-write unit. Decodes the
// instruction, reads the old CSR value, writes the updated value, and registers
// the old value for writeback to rd one cycle after issue. Assumes one
// instruction per cycle at most, with inputs stable around the rising edge.
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_CSR = 4,
    parameter logic [NUM_CSR*CSR_ADDR_W-1:0] ADDR_LIST =
        {12'hC00, 12'h340, 12'h305, 12'h300}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [6:0]            opcode,
    input  logic [2:0]            funct3,
    input  logic [CSR_ADDR_W-1:0] csr_addr,
    input  logic [REG_IDX_W-1:0]  rd_idx,
    input  logic [ZIMM_W-1:0]     rs1_idx,
    input  logic [XLEN-1:0]       rs1_value,
    output logic                  wb_we,
    output logic [REG_IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]       wb_data
);
    csr_ctl_t        ctl;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;
    logic            csr_we;
    logic            active;

    csr_op_decode u_decode (
        .op_valid (op_valid),
        .opcode   (opcode),
        .funct3   (funct3),
        .ctl      (ctl)
    );

    csr_update_alu #(.XLEN(XLEN)) u_alu (
        .kind      (ctl.kind),
        .use_imm   (ctl.use_imm),
        .rs1_value (rs1_value),
        .zimm      (rs1_idx),
        .old_val   (old_val),
        .new_val   (new_val),
        .wr_en     (csr_we)
    );

    csr_file #(
        .XLEN      (XLEN),
        .NUM_CSR   (NUM_CSR),
        .ADDR_LIST (ADDR_LIST)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (csr_addr),
        .wr_en   (csr_we),
        .wr_data (new_val),
        .rd_data (old_val)
    );

    assign active = (ctl.kind != CSR_NONE);

    // Register the writeback: strobe only for an active op with nonzero rd
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_we   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            wb_we <= active && (rd_idx != '0);
            if (active) begin
                wb_idx  <= rd_idx;
                wb_data <= old_val;
            end
        end
    end

    // R7
    no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (wb_idx != '0));
    // R6
    wb_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_valid && opcode == SYSTEM_OPCODE && funct3[1:0] != 2'b00 &&
         rd_idx != '0) |=> (wb_we && wb_data == $past(old_val) && wb_idx == $past(rd_idx)));
    // R9
    noop_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3[1:0] == 2'b00) |=> !wb_we);
endmodule

// File: tb/csr_rmw_unit_bench.sv
module csr_rmw_unit_bench;
    localparam int XLEN = 32;
    localparam int NUM  = 4;
    localparam logic [11:0] ADDRS [NUM] = '{12'h300, 12'h305, 12'h340, 12'hC00};
    localparam logic [11:0] MISS_ADDR = 12'h7FF;
    localparam logic [6:0]  SYS = 7'b1110011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [6:0]  opcode = '0;
    logic [2:0]  funct3 = '0;
    logic [11:0] csr_addr = '0;
    logic [4:0]  rd_idx = '0;
    logic [4:0]  rs1_idx = '0;
    logic [31:0] rs1_value = '0;
    logic        wb_we;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NUM];

    always #4 clk = ~clk;

    csr_rmw_unit u_csr_rmw_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .funct3(funct3), .csr_addr(csr_addr), .rd_idx(rd_idx), .rs1_idx(rs1_idx),
        .rs1_value(rs1_value), .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic int find_idx(input logic [11:0] a);
        for (int i = 0; i < NUM; i++) if (ADDRS[i] == a) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge, predict, check at the next falling edge
    task automatic issue(input logic v, input logic [6:0] opc, input logic [2:0] f,
                         input logic [11:0] a, input logic [4:0] rd, input logic [4:0] ri,
                         input logic [31:0] rv, input string tag);
        int idx;
        logic act, exp_we;
        logic [31:0] oldv, operand, newv;
        op_valid = v; opcode = opc; funct3 = f; csr_addr = a;
        rd_idx = rd; rs1_idx = ri; rs1_value = rv;
        idx = find_idx(a);
        oldv = (idx >= 0) ? model[idx] : 32'h0;
        act = v && (opc == SYS) && (f[1:0] != 2'b00);
        operand = f[2] ? {27'h0, ri} : rv;
        case (f[1:0])
            2'b01:   newv = operand;
            2'b10:   newv = oldv | operand;
            2'b11:   newv = oldv & ~operand;
            default: newv = oldv;
        endcase
        if (act && idx >= 0) model[idx] = newv;
        exp_we = act && (rd != 5'd0);
        @(negedge clk);
        check(wb_we === exp_we, {tag, " wb_we"}, {31'h0, wb_we}, {31'h0, exp_we});
        if (exp_we) begin
            check(wb_data === oldv, {tag, " wb_data R6"}, wb_data, oldv);
            check(wb_idx === rd, {tag, " wb_idx R6"}, {27'h0, wb_idx}, {27'h0, rd});
        end
    endtask

    // Read every CSR back with a zero-operand set, and the unlisted address
    task automatic read_all(input string tag);
        for (int i = 0; i < NUM; i++) issue(1'b1, SYS, 3'b010, ADDRS[i], 5'd5, 5'd0, 32'h0, tag);
        issue(1'b1, SYS, 3'b010, MISS_ADDR, 5'd5, 5'd0, 32'h0, {tag, " R8 miss"});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        string tag;
        for (int i = 0; i < NUM; i++) model[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(wb_we === 1'b0, "R1 reset wb_we", {31'h0, wb_we}, 32'h0);
        read_all("R1 reset readback");

        // Sweep every funct3 over listed and unlisted addresses, back to back (R11)
        for (int a = 0; a <= NUM; a++) begin
            for (int f = 0; f < 8; f++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [11:0] addr;
                    logic [4:0]  rd, ri;
                    logic [31:0] rv;
                    addr = (a == NUM) ? MISS_ADDR : ADDRS[a];
                    rd = (k == 0) ? 5'd0 : 5'(k + a + 1);
                    ri = 5'((k * 11 + f * 3 + a) % 32);
                    rv = 32'hA5A5_3C3C ^ (32'(k) * 32'h1357_9BDF) ^ (32'(a) << 7) ^ 32'(f);
                    if (f == 0 || f == 4)  tag = "R9";
                    else if (a == NUM)     tag = "R8";
                    else if (k == 0)       tag = "R7";
                    else if (f == 1)       tag = "R2";
                    else if (f == 2)       tag = "R3";
                    else if (f == 3)       tag = "R4";
                    else                   tag = "R5";
                    issue(1'b1, SYS, 3'(f), addr, rd, ri, rv, tag);
                end
            end
            read_all("R11 sweep readback");
        end

        // R5: immediate write ignores a busy register value
        issue(1'b1, SYS, 3'b101, ADDRS[1], 5'd3, 5'd31, 32'hFFFF_FFFF, "R5 imm write");
        issue(1'b1, SYS, 3'b010, ADDRS[1], 5'd3, 5'd0, 32'h0, "R5 imm readback");
        // R7: rd=0 write still lands
        issue(1'b1, SYS, 3'b001, ADDRS[2], 5'd0, 5'd0, 32'hDEAD_BEEF, "R7 x0 write");
        issue(1'b1, SYS, 3'b010, ADDRS[2], 5'd9, 5'd0, 32'h0, "R7 x0 readback");
        // R10: wrong opcode and low valid leave state alone
        issue(1'b1, 7'b0110011, 3'b001, ADDRS[0], 5'd4, 5'd7, 32'h1234_5678, "R10 opcode");
        issue(1'b0, SYS, 3'b001, ADDRS[0], 5'd4, 5'd7, 32'h8765_4321, "R10 invalid");
        read_all("R10 readback");
        // R9: environment call and breakpoint words
        issue(1'b1, SYS, 3'b000, 12'h000, 5'd0, 5'd0, 32'hFFFF_FFFF, "R9 ecall");
        issue(1'b1, SYS, 3'b000, 12'h001, 5'd0, 5'd0, 32'hFFFF_FFFF, "R9 ebreak");
        read_all("R9 readback");
        // R11: write then read on the next cycle
        issue(1'b1, SYS, 3'b001, ADDRS[3], 5'd1, 5'd0, 32'h0F0F_00FF, "R11 write");
        issue(1'b1, SYS, 3'b011, ADDRS[3], 5'd2, 5'd0, 32'h0000_000F, "R11 clear");
        issue(1'b1, SYS, 3'b010, ADDRS[3], 5'd3, 5'd0, 32'h0, "R11 read");
        op_valid = 1'b0;
        @(negedge clk);
        check(wb_we === 1'b0, "R10 idle wb_we", {31'h0, wb_we}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule